// File: doc/BRIEF.md
# Scatter-Gather Table DMA Walker

This block drives a host-memory port on behalf of a storage data path. Each transfer is described by a scatter-gather table in host memory, and every table entry names one contiguous region. The walker reads the entries one at a time and splits each region into bursts that never straddle a page. It keeps a running count of the command bytes still owed and reports a clean finish or an accounting error.

A command is loaded first. The command loads the total byte count and the data direction, and the walker waits in an armed state. A go strobe carries the table address and starts the walk. The memory port accepts a request with a grant or rejects it with busy. After a rejection the walker stays silent for a fixed back-off interval and then presents the same request again. Entry fetches return their 64-bit payload on a separate response strobe.

States: `WK_IDLE` (no command), `WK_ARMED` (command loaded, waiting for go), `WK_FETCH` (requesting a table entry), `WK_FETCH_WAIT` (waiting for the entry payload), `WK_BURST` (issuing page-bounded bursts) and `WK_BACKOFF` (waiting after busy). The transitions are:

- IDLE→ARMED on `cmd_arm`.
- ARMED→FETCH on `go`.
- FETCH→FETCH_WAIT on grant.
- FETCH_WAIT→BURST on `mem_rvalid`.
- BURST stays in BURST on a granted burst that is not the last one of the entry.
- BURST→FETCH on the last granted burst of an entry whose end flag is clear.
- BURST→IDLE at the end of the table (done or error), or on an overrun (error).
- FETCH→BACKOFF and BURST→BACKOFF on busy.
- BACKOFF→FETCH or BACKOFF→BURST when the interval expires, back to the step that was rejected.

Top module: `prd_dma_walker`

## Requirements
- R1: `cmd_arm` is accepted only in IDLE and `go` only in ARMED; a `go` in any other state has no effect. Once `go` is accepted, the table address is latched and the first entry request (`mem_req`=1, `mem_desc`=1, `mem_addr`=`table_base`) appears in the very next cycle.
- R2: Every entry fetch is an 8-byte memory read at the table pointer, and each granted fetch advances the pointer by 8. The entry payload has the following layout: the region base is in `mem_rdata[31:0]`, the byte count is in `mem_rdata[47:32]`, and the end-of-table flag is in `mem_rdata[63]`.
- R3: Every data burst has length min(bytes left in the entry, bytes left before the next PAGE_BYTES boundary) and starts where the previous burst ended. A burst therefore never crosses a page boundary and is never empty.
- R4: On busy the walker drops `mem_req` for exactly BACKOFF_CYC cycles and then re-presents the identical request.
- R5: Bursts for one entry continue until its byte count has been issued. The next entry is then fetched if the end flag is clear.
- R6: When the last burst of an entry with the end flag set is granted and the outstanding command count reaches exactly zero, `xfer_done` pulses for one cycle and the walker returns to IDLE.
- R7: If the next burst is longer than the outstanding command count, the burst is not requested. Instead `xfer_err` pulses once and the walker returns to IDLE.
- R8: If the end of the table is reached while the outstanding command count is not zero, `xfer_err` pulses instead of `xfer_done`.
- R9: With `cmd_disk_wr`=1 the bursts read memory (`mem_wr`=0). With `cmd_disk_wr`=0 they write memory with invalidate (`mem_wr`=1). Entry fetches always read.
- R10: An entry byte count of zero stands for 65536 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_arm | input | 1 | Load a command (IDLE only) |
| cmd_disk_wr | input | 1 | 1 = data goes to the disk (memory read) |
| cmd_bytes | input | CMD_W | Total command byte count |
| go | input | 1 | Start the table walk (ARMED only) |
| table_base | input | 32 | Address of the first table entry |
| mem_req | output | 1 | Request valid |
| mem_desc | output | 1 | Request is a table-entry fetch |
| mem_wr | output | 1 | 1 = memory write with invalidate |
| mem_addr | output | 32 | Request address |
| mem_len | output | 17 | Request length in bytes |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_busy | input | 1 | Request rejected this cycle |
| mem_rvalid | input | 1 | Entry payload valid |
| mem_rdata | input | 64 | Entry payload |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_err | output | 1 | One-cycle overrun/underrun pulse |

## Verification
The assertions check several properties on every cycle:

- Bursts are non-empty and stay inside one page.
- A rejected request is withdrawn at once, stays away for the full back-off and comes back unchanged.
- Consecutive fetches step the table pointer by one entry.
- The done and error pulses are single-cycle and mutually exclusive.

Only the scenarios can show the rest, because that needs a model of the table contents: that burst lengths follow the entry contents, that the walk stops exactly at the end flag, that the byte accounting picks done over error correctly, that the zero-count encoding means 64 KB, and that the direction bit maps to the right memory operation.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;

    localparam int ADDR_W      = 32;
    localparam int ENT_W       = 64;
    localparam int CNT_FIELD_W = 16;
    localparam int CNT_LSB     = 32;
    localparam int EOT_BIT     = 63;
    localparam int SPAN_W      = CNT_FIELD_W + 1;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_ARMED,
        WK_FETCH,
        WK_FETCH_WAIT,
        WK_BURST,
        WK_BACKOFF
    } wk_state_e;

    typedef struct packed {
        logic              last;
        logic [SPAN_W-1:0] span;
        logic [ADDR_W-1:0] base;
    } entry_t;

    function automatic entry_t decode_entry(input logic [ENT_W-1:0] raw);
        entry_t e;
        logic [CNT_FIELD_W-1:0] cnt;
        cnt    = raw[CNT_LSB +: CNT_FIELD_W];
        e.base = raw[ADDR_W-1:0];
        e.last = raw[EOT_BIT];
        e.span = (cnt == '0) ? SPAN_W'(1 << CNT_FIELD_W) : {1'b0, cnt};
        return e;
    endfunction

endpackage

// File: rtl/prd_burst_sizer.sv
module prd_burst_sizer #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 17,
    parameter int PAGE_BYTES = 8192
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  bytes_left,
    output logic [LEN_W-1:0]  burst_len
);
    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int RW   = (PG_W + 1 > LEN_W) ? PG_W + 1 : LEN_W;

    logic [RW-1:0] room;
    logic [RW-1:0] left_x;

    always_comb begin
        room      = RW'(PAGE_BYTES) - RW'(base_addr[PG_W-1:0]);
        left_x    = RW'(bytes_left);
        burst_len = LEN_W'((left_x < room) ? left_x : room);
    end
endmodule

// File: rtl/prd_backoff_timer.sv
module prd_backoff_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    generate
        if (CYCLES <= 1) begin : g_single
            assign expired = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(CYCLES);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            cnt_q <= '0;
                else if (load)         cnt_q <= CW'(CYCLES - 1);
                else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
            end
            assign expired = (cnt_q == '0);
        end
    endgenerate
endmodule

// File: rtl/prd_dma_walker.sv
module prd_dma_walker
    import prd_walk_pkg::*;
#(
    parameter int CMD_W       = 20,
    parameter int PAGE_BYTES  = 8192,
    parameter int BACKOFF_CYC = 16,
    parameter int ENT_BYTES   = 8,
    localparam int LEN_W      = SPAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_arm,
    input  logic              cmd_disk_wr,
    input  logic [CMD_W-1:0]  cmd_bytes,
    input  logic              go,
    input  logic [ADDR_W-1:0] table_base,
    output logic              mem_req,
    output logic              mem_desc,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    input  logic              mem_gnt,
    input  logic              mem_busy,
    input  logic              mem_rvalid,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              xfer_done,
    output logic              xfer_err
);
    wk_state_e          st_q, st_d;
    logic [ADDR_W-1:0]  ptr_q, addr_q;
    logic [LEN_W-1:0]   eleft_q;
    logic               elast_q;
    logic [CMD_W-1:0]   cleft_q;
    logic               dwr_q, retry_fetch_q, done_q, err_q;

    logic [LEN_W-1:0]   burst_len;
    logic               overrun, final_burst, bo_load, bo_expired;
    entry_t             fetched;

    prd_burst_sizer #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_sizer (
        .base_addr (addr_q),
        .bytes_left(eleft_q),
        .burst_len (burst_len)
    );

    always_comb begin
        overrun     = 32'(burst_len) > 32'(cleft_q);
        final_burst = (eleft_q == burst_len);
        fetched     = decode_entry(mem_rdata);
        bo_load     = mem_busy &&
                      ((st_q == WK_FETCH) || (st_q == WK_BURST && !overrun));
    end

    prd_backoff_timer #(.CYCLES(BACKOFF_CYC)) u_backoff (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (bo_load),
        .expired(bo_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WK_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WK_IDLE:       if (cmd_arm) st_d = WK_ARMED;
            WK_ARMED:      if (go)      st_d = WK_FETCH;
            WK_FETCH: begin
                if (mem_busy)      st_d = WK_BACKOFF;
                else if (mem_gnt)  st_d = WK_FETCH_WAIT;
            end
            WK_FETCH_WAIT: if (mem_rvalid) st_d = WK_BURST;
            WK_BURST: begin
                if (overrun)          st_d = WK_IDLE;
                else if (mem_busy)    st_d = WK_BACKOFF;
                else if (mem_gnt && final_burst)
                    st_d = elast_q ? WK_IDLE : WK_FETCH;
            end
            WK_BACKOFF: if (bo_expired) st_d = retry_fetch_q ? WK_FETCH : WK_BURST;
            default:       st_d = WK_IDLE;
        endcase
    end

    // datapath and status pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q         <= '0;
            addr_q        <= '0;
            eleft_q       <= '0;
            elast_q       <= 1'b0;
            cleft_q       <= '0;
            dwr_q         <= 1'b0;
            retry_fetch_q <= 1'b0;
            done_q        <= 1'b0;
            err_q         <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st_q)
                WK_IDLE: if (cmd_arm) begin
                    cleft_q <= cmd_bytes;
                    dwr_q   <= cmd_disk_wr;
                end
                WK_ARMED: if (go) ptr_q <= table_base;
                WK_FETCH: begin
                    if (mem_busy)     retry_fetch_q <= 1'b1;
                    else if (mem_gnt) ptr_q <= ptr_q + ADDR_W'(ENT_BYTES);
                end
                WK_FETCH_WAIT: if (mem_rvalid) begin
                    addr_q  <= fetched.base;
                    eleft_q <= fetched.span;
                    elast_q <= fetched.last;
                end
                WK_BURST: begin
                    if (overrun) begin
                        err_q <= 1'b1;
                    end else if (mem_busy) begin
                        retry_fetch_q <= 1'b0;
                    end else if (mem_gnt) begin
                        addr_q  <= addr_q + ADDR_W'(burst_len);
                        eleft_q <= eleft_q - burst_len;
                        cleft_q <= cleft_q - CMD_W'(burst_len);
                        if (final_burst && elast_q) begin
                            if (cleft_q == CMD_W'(burst_len)) done_q <= 1'b1;
                            else                               err_q  <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = (st_q == WK_FETCH) || (st_q == WK_BURST && !overrun);
        mem_desc  = (st_q == WK_FETCH);
        mem_wr    = (st_q == WK_BURST) && !dwr_q;
        mem_addr  = (st_q == WK_FETCH) ? ptr_q : addr_q;
        mem_len   = (st_q == WK_FETCH) ? LEN_W'(ENT_BYTES) : burst_len;
        xfer_done = done_q;
        xfer_err  = err_q;
    end
endmodule

// File: rtl/prd_dma_walker_chk.sv
module prd_dma_walker_chk #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 17,
    parameter int PAGE_BYTES  = 8192,
    parameter int BACKOFF_CYC = 16,
    parameter int ENT_BYTES   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_desc,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_len,
    input logic              mem_gnt,
    input logic              mem_busy,
    input logic              xfer_done,
    input logic              xfer_err
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    logic              held_v;
    logic [ADDR_W-1:0] held_addr;
    logic [LEN_W-1:0]  held_len;
    logic              held_desc;
    logic [15:0]       gap;
    logic              nxt_v;
    logic [ADDR_W-1:0] nxt_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_v <= 1'b0; held_addr <= '0; held_len <= '0; held_desc <= 1'b0;
            gap <= '0; nxt_v <= 1'b0; nxt_addr <= '0;
        end else begin
            if (mem_req && mem_busy) begin
                held_v <= 1'b1; held_addr <= mem_addr;
                held_len <= mem_len; held_desc <= mem_desc; gap <= '0;
            end else if (mem_req && mem_gnt) begin
                held_v <= 1'b0;
            end else if (held_v && !mem_req && gap != 16'hFFFF) begin
                gap <= gap + 1'b1;
            end
            if (xfer_done || xfer_err)                   nxt_v <= 1'b0;
            else if (mem_req && mem_desc && mem_gnt && !mem_busy) begin
                nxt_v    <= 1'b1;
                nxt_addr <= mem_addr + ADDR_W'(ENT_BYTES);
            end
        end
    end

    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_desc |-> (32'(mem_addr[PG_W-1:0]) + 32'(mem_len)) <= 32'(PAGE_BYTES)); // R3
    AST_BURST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_desc |-> mem_len != '0); // R3
    AST_BUSY_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_busy |=> !mem_req); // R4
    AST_RETRY_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        held_v && mem_req |-> (mem_addr == held_addr && mem_len == held_len && mem_desc == held_desc)); // R4
    AST_BACKOFF_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        held_v && mem_req |-> 32'(gap) == 32'(BACKOFF_CYC)); // R4
    AST_ENTRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_v && mem_req && mem_desc |-> mem_addr == nxt_addr); // R2
    AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_desc |-> !mem_wr && 32'(mem_len) == 32'(ENT_BYTES)); // R9
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && xfer_err)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R6
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> !xfer_err); // R7
endmodule

bind prd_dma_walker prd_dma_walker_chk #(
    .ADDR_W(prd_walk_pkg::ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
    .BACKOFF_CYC(BACKOFF_CYC), .ENT_BYTES(ENT_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_desc(mem_desc),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_gnt(mem_gnt), .mem_busy(mem_busy),
    .xfer_done(xfer_done), .xfer_err(xfer_err)
);

// File: tb/prd_dma_walker_tb.sv
`timescale 1ns/1ps
module prd_dma_walker_tb;
    localparam int CMD_W = 20;
    localparam int PAGE  = 8192;
    localparam int BO    = 16;

    typedef struct packed {
        logic        desc;
        logic        wr;
        logic [31:0] addr;
        logic [16:0] len;
    } req_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_arm = 0, cmd_disk_wr = 0, go = 0;
    logic [CMD_W-1:0] cmd_bytes = '0;
    logic [31:0] table_base = '0;
    logic mem_req, mem_desc, mem_wr, xfer_done, xfer_err;
    logic [31:0] mem_addr;
    logic [16:0] mem_len;
    logic mem_gnt = 0, mem_busy = 0, mem_rvalid = 0;
    logic [63:0] mem_rdata = '0;

    always #2 clk = ~clk;

    prd_dma_walker #(.CMD_W(CMD_W), .PAGE_BYTES(PAGE), .BACKOFF_CYC(BO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_disk_wr(cmd_disk_wr),
        .cmd_bytes(cmd_bytes), .go(go), .table_base(table_base),
        .mem_req(mem_req), .mem_desc(mem_desc), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
        .mem_busy(mem_busy), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .xfer_done(xfer_done), .xfer_err(xfer_err)
    );

    int n_checks = 0, n_fail = 0;
    req_t exp_q[$];
    logic [63:0] dtab [0:15];
    int req_events = 0, busy_a = -1, busy_b = -1;
    bit rsp_pend = 0, gap_on = 0;
    logic [3:0] rsp_idx = '0;
    int gap = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_entry(input int idx, input logic [31:0] base, input logic [15:0] cnt, input bit last);
        dtab[idx] = {last, 15'd0, cnt, base};
    endtask

    // monitor / memory responder / scoreboard
    always @(negedge clk) begin
        req_t got, e;
        mem_gnt = 0; mem_busy = 0; mem_rvalid = 0;
        if (rsp_pend) begin
            mem_rvalid = 1; mem_rdata = dtab[rsp_idx]; rsp_pend = 0;
        end
        if (rst_n && mem_req) begin
            if (gap_on) begin
                chk(gap == BO, "R4 backoff gap", gap, BO);
                gap_on = 0;
            end
            if (req_events == busy_a || req_events == busy_b) begin
                mem_busy = 1; gap_on = 1; gap = 0;
            end else begin
                mem_gnt = 1;
                got = '{desc: mem_desc, wr: mem_wr, addr: mem_addr, len: mem_len};
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected request", 64'(got), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e, e.desc ? "R2 fetch" : "R3 R9 burst", 64'(got), 64'(e));
                end
                if (mem_desc) begin rsp_pend = 1; rsp_idx = mem_addr[6:3]; end
            end
            req_events++;
        end else if (gap_on) begin
            gap++;
        end
    end

    task automatic run_xfer(input bit dwr, input int cmd, input logic [31:0] tbl,
                            input int ndesc, input string tag_end);
        int left = cmd;
        bit eerr = 0;
        int t = 0;
        for (int i = 0; i < ndesc; i++) begin
            logic [63:0] raw;
            int a, l, b;
            exp_q.push_back('{desc: 1'b1, wr: 1'b0, addr: tbl + 32'(8*i), len: 17'd8});
            raw = dtab[(tbl[6:3] + i) & 15];
            a = int'(raw[31:0]);
            l = (raw[47:32] == 0) ? 65536 : int'(raw[47:32]);
            while (l > 0) begin
                b = PAGE - (a % PAGE);
                if (b > l) b = l;
                if (b > left) begin eerr = 1; break; end
                exp_q.push_back('{desc: 1'b0, wr: !dwr, addr: 32'(a), len: 17'(b)});
                a += b; l -= b; left -= b;
            end
            if (eerr) break;
            if (raw[63]) begin
                if (left != 0) eerr = 1;
                break;
            end
        end
        req_events = 0;
        @(posedge clk); #1;
        cmd_arm = 1; cmd_disk_wr = dwr; cmd_bytes = CMD_W'(cmd);
        @(posedge clk); #1;
        cmd_arm = 0; go = 1; table_base = tbl;
        @(posedge clk); #1;
        go = 0;
        chk(mem_req && mem_desc && mem_addr == tbl, "R1 first fetch next cycle",
            {mem_req, mem_desc, mem_addr}, {2'b11, tbl});
        while (!(xfer_done || xfer_err) && t < 5000) begin
            @(posedge clk); #1; t++;
        end
        chk(xfer_done == !eerr && xfer_err == eerr, tag_end, {xfer_done, xfer_err}, {!eerr, eerr});
        @(posedge clk); #1;
        chk(!xfer_done && !xfer_err, "R6 single-cycle pulse", {xfer_done, xfer_err}, 0);
        chk(exp_q.size() == 0, "R5 all requests seen", exp_q.size(), 0);
        exp_q.delete();
        busy_a = -1; busy_b = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) dtab[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk(!mem_req && !xfer_done && !xfer_err, "R1 reset state",
            {mem_req, xfer_done, xfer_err}, 0);

        // R1: go while idle is ignored
        req_events = 0;
        @(posedge clk); #1; go = 1; table_base = 32'h100;
        @(posedge clk); #1; go = 0;
        repeat (10) @(posedge clk);
        #1 chk(req_events == 0 && !mem_req, "R1 go ignored when idle", req_events, 0);

        // single region, disk write -> memory read
        put_entry(0, 32'h0000_4000, 16'd1024, 1'b1);
        run_xfer(1'b1, 1024, 32'h0000_0100, 1, "R6 single entry done");

        // two entries, page crossing, busy on fetch and on burst, memory write
        put_entry(8, 32'h0000_1F00, 16'h0600, 1'b0);
        put_entry(9, 32'h0001_0000, 16'h4000, 1'b1);
        busy_a = 0; busy_b = 2;
        run_xfer(1'b0, 32'h600 + 32'h4000, 32'h0000_0240, 2, "R5 R6 two entries done");

        // R10: zero count means 64 KB, busy on a mid burst
        put_entry(4, 32'h0002_0000, 16'h0000, 1'b1);
        busy_a = 5;
        run_xfer(1'b1, 65536, 32'h0000_0320, 1, "R10 R6 64KB entry done");

        // R3: unaligned start inside a page
        put_entry(2, 32'h0000_7F80, 16'h0200, 1'b1);
        run_xfer(1'b0, 32'h200, 32'h0000_0010, 1, "R3 R6 unaligned entry done");

        // R7: overrun, burst bigger than command count
        put_entry(6, 32'h0000_5000, 16'd1024, 1'b1);
        run_xfer(1'b1, 512, 32'h0000_0030, 1, "R7 overrun error");

        // R8: table ends with bytes still owed
        put_entry(7, 32'h0000_6000, 16'd1024, 1'b1);
        run_xfer(1'b1, 2048, 32'h0000_0038, 1, "R8 underrun error");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule